// File: doc/BRIEF.md
# Stream Engine Control Register Bank

This block is the register bank that a host processor uses to configure and observe one streaming data engine. The host reaches it over a simple 32-bit memory-mapped port that carries single-beat writes and single-beat reads, in the style of a reduced AXI4-Lite slave. The bank holds the engine's configuration in registers and drives each field straight out as a port. The fields are a reset bit, a run bit, a frame length that sets how often the end-of-frame marker is raised, an iteration count where zero means endless operation, and a memory wrap address. The bank also samples the engine's done status so that the host can poll it.

The configuration words are write-only, so reading them returns zero. Only two words return data on a read. One is a fixed identifier, set by a parameter. The other is the done status, which sits at its own offset away from the configuration words. Any offset that the bank does not decode reads as zero, and writes to it are dropped. Byte strobes are not part of the port: every write replaces the whole field.

Top module: `strm_ctl_regs`

## Requirements
- R1: After reset, eng_rst, eng_run, frame_len, iter_cnt and wrap_addr are all zero, and rd_valid and rd_data are zero.
- R2: A read of byte offset 0x00 returns the ID_VALUE parameter on rd_data.
- R3: A write to offset 0x04 sets eng_rst from data bit 0 and eng_run from data bit 4 on the next clock edge. All other data bits of that word are discarded.
- R4: A write to offset 0x08 loads frame_len from data bits [11:0]. Data bits [31:12] are discarded.
- R5: A write to offset 0x0C loads iter_cnt from data bits [11:0]. The value 0 is stored unchanged and means endless operation.
- R6: A write to offset 0x10 loads wrap_addr from data bits [15:0].
- R7: A read of offset 0x20 returns, in bit 0, the value of eng_done registered on the clock edge before the read edge. Bits [31:1] of that read are zero.
- R8: Reads of the write-only offsets 0x04, 0x08, 0x0C and 0x10, and of any undecoded offset, return zero.
- R9: Writes to offsets 0x00 and 0x20, and to any undecoded offset, leave every configuration output unchanged.
- R10: While wr_en is low, every configuration output holds its value.
- R11: Address bits [1:0] are ignored. Decoding uses only the word address, which is addr[AW-1:2].
- R12: rd_valid is high in exactly the cycle after a cycle with rd_en high. In every other cycle rd_valid is low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-beat write request |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Single-beat read request |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 32 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | Read response strobe, one cycle after rd_en |
| eng_done | input | 1 | Done status from the engine |
| eng_rst | output | 1 | Engine reset, active high |
| eng_run | output | 1 | Engine run enable |
| frame_len | output | 12 | Beats per frame |
| iter_cnt | output | 12 | Iteration count, 0 means endless |
| wrap_addr | output | 16 | Memory wrap address |

## Verification
On every cycle, the assertions check the following properties:
- the one-cycle read response and the zero data returned when no response is due;
- the identifier returned by reads of offset 0x00;
- zero data returned by reads of non-readable offsets;
- that configuration outputs hold when no write is made, and when writes go to read-only or undecoded offsets;
- that frame-length writes are loaded.

Some behaviours need the bench's scenarios to show them:
- the bit placement in the shared reset/run word, with its discarded bits;
- truncation of over-wide data;
- storage of a zero iteration count;
- the delay with which the done status appears;
- the ignored low address bits.

The bench covers these with a mix of directed and random writes and reads.

// File: rtl/strm_ctl_pkg.sv
package strm_ctl_pkg;

    localparam int DATA_W   = 32;
    localparam int FLEN_W   = 12;
    localparam int ITER_W   = 12;
    localparam int WRAP_W   = 16;
    localparam int RST_BIT  = 0;
    localparam int RUN_BIT  = 4;
    localparam int NUM_REGS = 6;

    typedef enum int {
        REG_ID   = 0,
        REG_CTRL = 1,
        REG_FLEN = 2,
        REG_ITER = 3,
        REG_WRAP = 4,
        REG_DONE = 5
    } reg_idx_e;

    // word (not byte) offset of each register
    function automatic int reg_word(input int idx);
        case (idx)
            REG_ID:   return 0;
            REG_CTRL: return 1;
            REG_FLEN: return 2;
            REG_ITER: return 3;
            REG_WRAP: return 4;
            REG_DONE: return 8;
            default:  return -1;
        endcase
    endfunction

    typedef struct packed {
        logic              rst;
        logic              run;
        logic [FLEN_W-1:0] flen;
        logic [ITER_W-1:0] iter;
        logic [WRAP_W-1:0] wrap;
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } bank_state_t;

endpackage

// File: rtl/strm_ctl_decode.sv
module strm_ctl_decode
    import strm_ctl_pkg::*;
#(
    parameter int WW = 6
) (
    input  logic [WW-1:0]       waddr,
    output logic [NUM_REGS-1:0] hit
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = (waddr == WW'(reg_word(i)));
    end

    always_comb begin
        a_r11_decode_onehot: assert ($onehot0(hit))
            else $error("decoder matched more than one register");
    end

endmodule

// File: rtl/strm_ctl_rdmux.sv
module strm_ctl_rdmux
    import strm_ctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
    input  logic [NUM_REGS-1:0] hit,
    input  logic                done,
    output logic [DATA_W-1:0]   word
);

    always_comb begin
        word = '0;
        if (hit[REG_ID])   word = ID_VALUE;
        if (hit[REG_DONE]) word = {{(DATA_W-1){1'b0}}, done};
    end

endmodule

// File: rtl/strm_ctl_regs.sv
module strm_ctl_regs
    import strm_ctl_pkg::*;
#(
    parameter int                AW       = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'hC7A1_0005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              eng_done,
    output logic              eng_rst,
    output logic              eng_run,
    output logic [FLEN_W-1:0] frame_len,
    output logic [ITER_W-1:0] iter_cnt,
    output logic [WRAP_W-1:0] wrap_addr
);

    localparam int WW = AW - 2;

    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] rd_hit;
    logic [DATA_W-1:0]   rd_word;
    bank_state_t         st_d, st_q;

    logic unused_bits;
    assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data[DATA_W-1:WRAP_W]};

    strm_ctl_decode #(.WW(WW)) i_wr_dec (.waddr(wr_addr[AW-1:2]), .hit(wr_hit));
    strm_ctl_decode #(.WW(WW)) i_rd_dec (.waddr(rd_addr[AW-1:2]), .hit(rd_hit));

    strm_ctl_rdmux #(.ID_VALUE(ID_VALUE)) i_rdmux (
        .hit  (rd_hit),
        .done (st_q.done),
        .word (rd_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = eng_done;
        st_d.rvalid = rd_en;
        st_d.rdata  = rd_en ? rd_word : '0;
        if (wr_en) begin
            if (wr_hit[REG_CTRL]) begin
                st_d.rst = wr_data[RST_BIT];
                st_d.run = wr_data[RUN_BIT];
            end
            if (wr_hit[REG_FLEN]) st_d.flen = wr_data[FLEN_W-1:0];
            if (wr_hit[REG_ITER]) st_d.iter = wr_data[ITER_W-1:0];
            if (wr_hit[REG_WRAP]) st_d.wrap = wr_data[WRAP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rdata;
    assign rd_valid  = st_q.rvalid;
    assign eng_rst   = st_q.rst;
    assign eng_run   = st_q.run;
    assign frame_len = st_q.flen;
    assign iter_cnt  = st_q.iter;
    assign wrap_addr = st_q.wrap;

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && rd_data == '0));
    a_r2_id_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_hit[REG_ID]) |=> rd_data == ID_VALUE);
    a_r8_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit[REG_ID] && !rd_hit[REG_DONE]) |=> rd_data == '0);
    a_r4_flen_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit[REG_FLEN]) |=> frame_len == $past(wr_data[FLEN_W-1:0]));
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(eng_rst) && $stable(eng_run) && $stable(frame_len)
                    && $stable(iter_cnt) && $stable(wrap_addr)));
    a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit[REG_CTRL] && !wr_hit[REG_FLEN] && !wr_hit[REG_ITER]
         && !wr_hit[REG_WRAP])
        |=> ($stable(eng_rst) && $stable(eng_run) && $stable(frame_len)
             && $stable(iter_cnt) && $stable(wrap_addr)));

endmodule

// File: tb/test_strm_ctl_regs.sv
module test_strm_ctl_regs;

    localparam int          AW  = 8;
    localparam logic [31:0] IDV = 32'hC7A1_0005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, eng_done = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid, eng_rst, eng_run;
    logic [11:0] frame_len, iter_cnt;
    logic [15:0] wrap_addr;

    int checks = 0, errors = 0;

    // bench model
    logic        m_rst = 0, m_run = 0, m_done = 0;
    logic [11:0] m_flen = 0, m_iter = 0;
    logic [15:0] m_wrap = 0;

    always #4 clk = ~clk;

    strm_ctl_regs #(.AW(AW), .ID_VALUE(IDV)) i_strm_ctl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .eng_done(eng_done),
        .eng_rst(eng_rst), .eng_run(eng_run), .frame_len(frame_len),
        .iter_cnt(iter_cnt), .wrap_addr(wrap_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a[AW-1:2])
            6'd0:    return IDV;
            6'd8:    return {31'b0, m_done};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string wr_req(input logic [AW-1:0] a);
        case (a[AW-1:2])
            6'd1: return "R3";
            6'd2: return "R4";
            6'd3: return "R5";
            6'd4: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check_cfg(input string req);
        check(req, {31'b0, eng_rst}, {31'b0, m_rst});
        check(req, {31'b0, eng_run}, {31'b0, m_run});
        check(req, {20'b0, frame_len}, {20'b0, m_flen});
        check(req, {20'b0, iter_cnt}, {20'b0, m_iter});
        check(req, {16'b0, wrap_addr}, {16'b0, m_wrap});
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        case (a[AW-1:2])
            6'd1: begin m_rst = d[0]; m_run = d[4]; end
            6'd2: m_flen = d[11:0];
            6'd3: m_iter = d[11:0];
            6'd4: m_wrap = d[15:0];
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
        check_cfg(wr_req(a));
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        logic [31:0] e;
        e = exp_read(a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check("R12", {31'b0, rd_valid}, 32'd1);
        check(req, rd_data, e);
        @(negedge clk);
        check("R12", {31'b0, rd_valid}, 32'd0);
        check("R12", rd_data, 32'h0);
    endtask

    task automatic set_done(input logic v);
        eng_done = v; m_done = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_cfg("R1");
        check("R1", {31'b0, rd_valid}, 32'd0);
        check("R1", rd_data, 32'h0);

        do_read(8'h00, "R2");
        do_write(8'h04, 32'hFFFF_FFEE);            // R3: bit0=0 bit4=0 with noise
        do_write(8'h04, 32'h0000_0011);            // R3: both set
        do_write(8'h04, 32'h0000_0010);            // R3: run only
        do_write(8'h08, 32'hABCD_E123);            // R4: truncated
        do_write(8'h0C, 32'h0000_0FFF);            // R5
        do_write(8'h0C, 32'hFFFF_0000);            // R5: zero stored
        do_write(8'h10, 32'h1234_BEEF);            // R6
        do_write(8'h00, 32'hFFFF_FFFF);            // R9 ID offset
        do_write(8'h20, 32'hFFFF_FFFF);            // R9 done offset
        do_write(8'h14, 32'hFFFF_FFFF);            // R9 undecoded
        do_write(8'h0B, 32'h0000_0777);            // R11 low bits ignored
        check("R11", {20'b0, frame_len}, 32'h777);
        do_read(8'h08, "R8");
        do_read(8'h10, "R8");
        do_read(8'h3C, "R8");
        do_read(8'h03, "R11");
        set_done(1'b1);
        do_read(8'h20, "R7");
        do_read(8'h22, "R11");
        set_done(1'b0);
        do_read(8'h20, "R7");
        // R10 idle hold
        repeat (5) @(negedge clk);
        check_cfg("R10");

        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            int            k;
            k = $urandom_range(0, 9);
            a = (k < 7) ? AW'({$urandom_range(0, 9), 2'($urandom_range(0, 3))})
                        : AW'($urandom);
            d = $urandom;
            if (k == 9) set_done(d[7]);
            if (d[0]) do_write(a, d);
            else      do_read(a, "R8");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule